// File: doc/BRIEF.md
# Wait-for-Interrupt and Interrupt Sampling Sequencer

This block is the cycle-level interrupt control slice of a small CPU core. The core steps it one CPU cycle per clock. It tells the block when an instruction starts, what class of instruction it is, and which cycle is the final one. The block holds the interrupt-disable flag. It tracks a level-sensitive IRQ line and an edge-triggered NMI line, both active low. It decides, at the final cycle of each instruction, whether the core should branch to an interrupt vector and which vector to use.

The block runs the wait-for-interrupt instruction on its own. If an interrupt is already pending, the instruction is short: one read cycle and then two internal cycles. If nothing is pending, the core idles in internal cycles. The wake-up happens in the same cycle that the IRQ line goes low or the NMI line falls. Two more internal cycles then close the instruction. When the disable flag is set, an IRQ still ends the wait, but no vector is taken. Instructions that write the disable flag commit the new value at the end of their final cycle, which is after the interrupt check of that same cycle has used the old value.

Top module: `wfi_int_seq`

## Requirements
- R1: After reset, the disable flag `iflag` is 1, no NMI is pending, `instr_done`, `take_int` and `take_nmi` are 0, and the cycle type `cyc_io` is 0 (read).
- R2: For a plain instruction (op_class 0) or a flag-writing instruction (op_class 2), `instr_done` is high exactly in the cycles where `last_cycle` is high, and `cyc_io` stays 0.
- R3: `take_int` is high in a final cycle only if the interrupt was pending at the start of that cycle. An IRQ is pending when `irq_n` was low in the previous cycle and `iflag` is 0. An IRQ line that first goes low during the final cycle is not taken by that instruction.
- R4: A flag-writing instruction loads `flag_new` into `iflag` at the clock edge that ends its final cycle. The interrupt check in that final cycle uses the old flag value. `iflag` changes at no other time.
- R5: A wait instruction (op_class 1) that starts while an interrupt is pending (a latched NMI, or `irq_n` low in the previous cycle, masked or not) takes exactly 3 cycles: read, internal, internal. `instr_done` is high on the third cycle.
- R6: A wait instruction that starts with nothing pending gives one read cycle and then internal cycles (`cyc_io`=1, `instr_done`=0) for as long as no interrupt arrives.
- R7: While idling, the cycle in which `irq_n` is low or `nmi_n` falls is the wake cycle. The instruction then finishes with exactly two more internal cycles, and `instr_done` is high on the second of them.
- R8: With `iflag` at 1, a wait instruction still ends on IRQ, but `take_int` stays 0 and the next instruction also takes no vector.
- R9: A falling edge on `nmi_n` is latched even if the line returns high. The latch stays set until an NMI is taken and is then cleared, so the next instruction does not take it again.
- R10: When an NMI and an unmasked IRQ are both pending in a final cycle, `take_nmi` is 1. `take_nmi` is never high without `take_int`.
- R11: `last_cycle` has no effect during a wait instruction's internal cycles.
- R12: `take_int` is high only in a cycle where `instr_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one CPU cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 1 | Level-sensitive interrupt request, active low |
| nmi_n | input | 1 | Non-maskable interrupt, active on falling edge |
| instr_start | input | 1 | High in the first cycle of an instruction |
| op_class | input | 2 | Instruction class at start: 0 plain, 1 wait, 2 flag write |
| last_cycle | input | 1 | High in the final cycle of a plain or flag-write instruction |
| flag_new | input | 1 | Flag value written by a flag-write instruction in its final cycle |
| cyc_io | output | 1 | Cycle type: 0 read, 1 internal |
| instr_done | output | 1 | High in the final cycle of the current instruction |
| take_int | output | 1 | Branch to an interrupt vector after this instruction |
| take_nmi | output | 1 | The vector taken is the NMI one |
| iflag | output | 1 | Current interrupt-disable flag |

## Verification
The bound checker checks on every cycle that a vector is requested only in a final cycle and that NMI priority never appears without a take. It also checks that an IRQ take is backed by a line that was low one cycle earlier and an open mask, that the flag moves only after a final cycle, and that the idle, wake and closing cycles of the wait sequence follow one another. The exact cycle counts of the short, long and masked wait sequences need directed scenarios. So do the boundary between an IRQ that arrives just before the final cycle and one that arrives during it, the old-flag check in a flag write, and the clearing of a latched NMI. The bench shows these by counting cycles at the ports.

// File: rtl/wfi_pkg.sv
package wfi_pkg;

    typedef enum logic [1:0] {
        OPC_PLAIN = 2'd0,
        OPC_WAIT  = 2'd1,
        OPC_FLAG  = 2'd2,
        OPC_RSVD  = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SLEEP = 2'd1,
        SQ_IO1   = 2'd2,
        SQ_IO2   = 2'd3
    } seq_state_e;

    // Interrupt view seen by the sequencer in the current cycle
    typedef struct packed {
        logic nmi_pend;   // latched NMI edge, registered
        logic irq_act;    // IRQ level sampled at the last edge
        logic nmi_fall;   // NMI falling in this cycle
        logic irq_now;    // IRQ level in this cycle
    } int_view_t;

    // Anything that ends a wait
    function automatic logic wake_any(int_view_t v);
        return v.nmi_pend | v.irq_act | v.nmi_fall | v.irq_now;
    endfunction

    // Pending at start of cycle, mask ignored (wait length choice)
    function automatic logic pend_raw(int_view_t v);
        return v.nmi_pend | v.irq_act;
    endfunction

    // Pending at start of cycle for vectoring
    function automatic logic pend_vec(int_view_t v, logic mask);
        return v.nmi_pend | (v.irq_act & ~mask);
    endfunction

endpackage

// File: rtl/wfi_int_sense.sv
module wfi_int_sense
    import wfi_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      irq_n,
    input  logic      nmi_n,
    input  logic      nmi_ack,
    output int_view_t view
);
    logic irq_act_q;
    logic nmi_prev_q;
    logic nmi_pend_q;
    logic nmi_fall;

    assign nmi_fall = nmi_prev_q & ~nmi_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_act_q  <= 1'b0;
            nmi_prev_q <= 1'b1;
            nmi_pend_q <= 1'b0;
        end else begin
            irq_act_q  <= ~irq_n;
            nmi_prev_q <= nmi_n;
            nmi_pend_q <= nmi_fall | (nmi_pend_q & ~nmi_ack);
        end
    end

    always_comb begin
        view.nmi_pend = nmi_pend_q;
        view.irq_act  = irq_act_q;
        view.nmi_fall = nmi_fall;
        view.irq_now  = ~irq_n;
    end
endmodule

// File: rtl/wfi_seq_fsm.sv
module wfi_seq_fsm
    import wfi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       instr_start,
    input  op_class_e  cls_in,
    input  logic       last_cycle,
    input  int_view_t  view,
    output seq_state_e state,
    output logic       cyc_io,
    output logic       done,
    output op_class_e  cls_eff
);
    seq_state_e st_q, st_d;
    op_class_e  cls_q;
    logic       start_here;

    assign start_here = instr_start && (st_q == SQ_IDLE);

    always_comb begin
        st_d   = st_q;
        cyc_io = 1'b1;
        done   = 1'b0;
        case (st_q)
            SQ_IDLE: begin
                cyc_io = 1'b0;
                if (start_here && cls_in == OPC_WAIT)
                    st_d = pend_raw(view) ? SQ_IO1 : SQ_SLEEP;
                else
                    done = last_cycle;
            end
            SQ_SLEEP: if (wake_any(view)) st_d = SQ_IO1;
            SQ_IO1:   st_d = SQ_IO2;
            SQ_IO2: begin
                done = 1'b1;
                st_d = SQ_IDLE;
            end
            default:  st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SQ_IDLE;
            cls_q <= OPC_PLAIN;
        end else begin
            st_q <= st_d;
            if (start_here) cls_q <= cls_in;
        end
    end

    assign cls_eff = start_here ? cls_in : cls_q;
    assign state   = st_q;
endmodule

// File: rtl/wfi_flag_reg.sv
module wfi_flag_reg #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  logic new_val,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)         flag <= RST_VAL;
        else if (commit) flag <= new_val;
    end
endmodule

// File: rtl/wfi_int_seq.sv
module wfi_int_seq
    import wfi_pkg::*;
#(
    parameter logic FLAG_RST_VAL = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       irq_n,
    input  logic       nmi_n,
    input  logic       instr_start,
    input  logic [1:0] op_class,
    input  logic       last_cycle,
    input  logic       flag_new,
    output logic       cyc_io,
    output logic       instr_done,
    output logic       take_int,
    output logic       take_nmi,
    output logic       iflag
);
    int_view_t  view;
    seq_state_e seq_state;
    op_class_e  cls_eff;
    logic       flag_commit;

    wfi_int_sense u_sense (
        .clk     (clk),
        .rst     (rst),
        .irq_n   (irq_n),
        .nmi_n   (nmi_n),
        .nmi_ack (take_nmi),
        .view    (view)
    );

    wfi_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .instr_start (instr_start),
        .cls_in      (op_class_e'(op_class)),
        .last_cycle  (last_cycle),
        .view        (view),
        .state       (seq_state),
        .cyc_io      (cyc_io),
        .done        (instr_done),
        .cls_eff     (cls_eff)
    );

    // Flag write lands after the check made in the same final cycle
    assign flag_commit = instr_done && (cls_eff == OPC_FLAG);

    wfi_flag_reg #(.RST_VAL(FLAG_RST_VAL)) u_flag (
        .clk     (clk),
        .rst     (rst),
        .commit  (flag_commit),
        .new_val (flag_new),
        .flag    (iflag)
    );

    assign take_int = instr_done & pend_vec(view, iflag);
    assign take_nmi = instr_done & view.nmi_pend;
endmodule

// File: rtl/wfi_int_seq_chk.sv
module wfi_int_seq_chk
    import wfi_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       irq_n,
    input logic       iflag,
    input logic       cyc_io,
    input logic       instr_done,
    input logic       take_int,
    input logic       take_nmi,
    input seq_state_e st
);
    p_take_in_final_r12: assert property (@(posedge clk) disable iff (rst)
        take_int |-> instr_done);

    p_nmi_prio_r10: assert property (@(posedge clk) disable iff (rst)
        take_nmi |-> take_int);

    p_irq_sampled_r3: assert property (@(posedge clk) disable iff (rst)
        (take_int && !take_nmi) |-> ($past(!irq_n) && !iflag));

    p_flag_after_final_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(iflag) |-> $past(instr_done));

    p_sleep_io_r6: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_SLEEP) |-> (cyc_io && !instr_done));

    p_wake_now_r7: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_SLEEP && !irq_n) |=> (st == SQ_IO1));

    p_close_r5: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_IO1) |=> (instr_done && cyc_io));
endmodule

bind wfi_int_seq wfi_int_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_n      (irq_n),
    .iflag      (iflag),
    .cyc_io     (cyc_io),
    .instr_done (instr_done),
    .take_int   (take_int),
    .take_nmi   (take_nmi),
    .st         (seq_state)
);

// File: tb/wfi_int_seq_tb.sv
module wfi_int_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       irq_n = 1'b1;
    logic       nmi_n = 1'b1;
    logic       instr_start = 1'b0;
    logic [1:0] op_class = 2'd0;
    logic       last_cycle = 1'b0;
    logic       flag_new = 1'b0;
    logic       cyc_io, instr_done, take_int, take_nmi, iflag;

    logic s_io, s_done, s_take, s_nmi, s_flag;
    int   n_run = 0;
    int   n_fail = 0;

    always #5 clk = ~clk;

    wfi_int_seq dut_i (
        .clk(clk), .rst(rst), .irq_n(irq_n), .nmi_n(nmi_n),
        .instr_start(instr_start), .op_class(op_class),
        .last_cycle(last_cycle), .flag_new(flag_new),
        .cyc_io(cyc_io), .instr_done(instr_done), .take_int(take_int),
        .take_nmi(take_nmi), .iflag(iflag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Sample mid-cycle, then advance; strobes drop after each cycle
    task automatic tick();
        @(negedge clk);
        s_io = cyc_io; s_done = instr_done; s_take = take_int;
        s_nmi = take_nmi; s_flag = iflag;
        @(posedge clk); #1;
        instr_start = 1'b0;
        last_cycle  = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic flag_op(input logic v);
        instr_start = 1'b1; op_class = 2'd2; flag_new = v; last_cycle = 1'b1;
        tick();
    endtask

    task automatic plain1();
        instr_start = 1'b1; op_class = 2'd0; last_cycle = 1'b1;
        tick();
    endtask

    task automatic wait_start();
        instr_start = 1'b1; op_class = 2'd1;
        tick();
    endtask

    task automatic t_reset();
        idle(1);
        chk("R1 iflag", s_flag, 1);
        chk("R1 done", s_done, 0);
        chk("R1 take", s_take, 0);
        chk("R1 io", s_io, 0);
        plain1();
        chk("R1 no nmi pending", s_take, 0);
    endtask

    task automatic t_plain();
        instr_start = 1'b1; op_class = 2'd0; tick();
        chk("R2 c1 done", s_done, 0);
        chk("R2 c1 io", s_io, 0);
        tick();
        chk("R2 c2 done", s_done, 0);
        last_cycle = 1'b1; tick();
        chk("R2 c3 done", s_done, 1);
        chk("R2 c3 io", s_io, 0);
    endtask

    task automatic t_sample();
        flag_op(1'b0);
        chk("R2 flag op done", s_done, 1);
        idle(1);
        chk("R4 cleared flag", s_flag, 0);
        instr_start = 1'b1; op_class = 2'd0; tick();
        irq_n = 1'b0; last_cycle = 1'b1; tick();
        chk("R3 late irq not taken", s_take, 0);
        chk("R3 done", s_done, 1);
        plain1();
        chk("R3 irq taken next", s_take, 1);
        chk("R3 not nmi", s_nmi, 0);
        irq_n = 1'b1; idle(2);
    endtask

    task automatic t_flag();
        irq_n = 1'b0; idle(1);
        flag_op(1'b1);
        chk("R4 set uses old flag", s_take, 1);
        plain1();
        chk("R4 masked after set", s_take, 0);
        chk("R4 flag now set", s_flag, 1);
        flag_op(1'b0);
        chk("R4 clear uses old flag", s_take, 0);
        plain1();
        chk("R4 taken after clear", s_take, 1);
        irq_n = 1'b1; idle(2);
    endtask

    task automatic t_short_wait();
        flag_op(1'b1);
        irq_n = 1'b0; idle(1);
        wait_start();
        chk("R5 c1 read", s_io, 0);
        chk("R5 c1 done", s_done, 0);
        tick();
        chk("R5 c2 io", s_io, 1);
        chk("R5 c2 done", s_done, 0);
        tick();
        chk("R5 c3 io", s_io, 1);
        chk("R5 c3 done", s_done, 1);
        chk("R8 short masked take", s_take, 0);
        irq_n = 1'b1; idle(2);
    endtask

    task automatic t_long_wait();
        flag_op(1'b0);
        wait_start();
        chk("R6 first read", s_io, 0);
        for (int i = 0; i < 4; i++) begin
            last_cycle = 1'b1; tick();
            chk("R6 idle io", s_io, 1);
            chk("R11 last_cycle ignored", s_done, 0);
        end
        irq_n = 1'b0; tick();
        chk("R7 wake cycle done", s_done, 0);
        tick();
        chk("R7 close1 done", s_done, 0);
        chk("R7 close1 io", s_io, 1);
        tick();
        chk("R7 close2 done", s_done, 1);
        chk("R7 irq taken", s_take, 1);
        chk("R7 not nmi", s_nmi, 0);
        irq_n = 1'b1; idle(2);
    endtask

    task automatic t_masked_wait();
        flag_op(1'b1);
        wait_start();
        idle(2);
        chk("R6 masked idle", s_done, 0);
        irq_n = 1'b0; tick();
        tick();
        tick();
        chk("R8 wait ends", s_done, 1);
        chk("R8 no vector", s_take, 0);
        plain1();
        chk("R8 next no vector", s_take, 0);
        irq_n = 1'b1; idle(2);
        chk("R8 flag kept", s_flag, 1);
    endtask

    task automatic t_nmi();
        flag_op(1'b0);
        nmi_n = 1'b0; tick();
        nmi_n = 1'b1; idle(3);
        instr_start = 1'b1; op_class = 2'd0; tick();
        chk("R12 no take mid instr", s_take, 0);
        last_cycle = 1'b1; tick();
        chk("R9 nmi latched taken", s_take, 1);
        chk("R9 nmi vector", s_nmi, 1);
        plain1();
        chk("R9 nmi cleared", s_take, 0);
        irq_n = 1'b0; nmi_n = 1'b0; tick();
        nmi_n = 1'b1;
        plain1();
        chk("R10 nmi wins", s_nmi, 1);
        chk("R10 take", s_take, 1);
        plain1();
        chk("R10 irq after", s_take, 1);
        chk("R10 irq vector", s_nmi, 0);
        irq_n = 1'b1; idle(2);
        wait_start();
        idle(2);
        nmi_n = 1'b0; tick();
        chk("R7 nmi wake cycle", s_done, 0);
        nmi_n = 1'b1; tick();
        tick();
        chk("R7 nmi close done", s_done, 1);
        chk("R7 nmi vector", s_nmi, 1);
        idle(2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_plain();
        t_sample();
        t_flag();
        t_short_wait();
        t_long_wait();
        t_masked_wait();
        t_nmi();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule